// File: doc/BRIEF.md
# Byte-Addressed Load/Store Memory Unit

This block sits between a 32-bit datapath and a small on-chip RAM in which every address names one 8-bit location. Each request adds a base value from the register file to a signed immediate offset to form the effective address. It then performs one of four operations: load a byte, store a byte, load a word or store a word. Byte loads come back sign-extended to 32 bits. Byte stores write only the low byte of the store data. Words span four consecutive locations, and the most significant byte sits at the lowest address.

A request is accepted only when the select input is high. The write input then chooses a store (1) or a load (0). A word access whose effective address is not a multiple of four is refused: memory and the returned-data register are both left untouched, and the fault output goes high instead. Load data, the load-valid strobe and the fault flag are all registered, so they appear one clock after the request. The internal array is read combinationally and written on the rising clock edge. Its depth is 2^ADDR_W bytes.

Top module: `bytemem_lsu`

## Requirements
- R1: The effective address is req_base plus req_offset sign-extended from OFFSET_W bits. Only its low ADDR_W bits select a location, so the address wraps modulo 2^ADDR_W.
- R2: A word at address A occupies locations A, A+1, A+2 and A+3. A holds bits 31:24, A+1 holds 23:16, A+2 holds 15:8 and A+3 holds 7:0.
- R3: A byte load (req_cs=1, req_we=0, req_word=0) sign-extends the addressed byte into ld_data, so 0x80 returns 0xFFFFFF80 and 0x11 returns 0x00000011. ld_data and ld_valid=1 appear on the clock after the request.
- R4: A byte store (req_cs=1, req_we=1, req_word=0) writes req_wdata[7:0] into the addressed location only. The neighbouring locations are unchanged.
- R5: An aligned word store writes all 32 bits of req_wdata into four locations. A later aligned word load at the same address returns that value in ld_data, with ld_valid=1, one clock after the request.
- R6: A word access (req_word=1) whose effective address has a nonzero value in bits 1:0 makes bus_fault high for exactly the following cycle, and ld_valid stays low.
- R7: A faulting word store changes no memory location.
- R8: A faulting word load leaves ld_data at its previous value.
- R9: While req_cs=0 nothing is written, whatever req_we is. The next cycle shows ld_valid=0, bus_fault=0 and an unchanged ld_data.
- R10: While rst_n is low, ld_data is 0 and ld_valid and bus_fault are low.
- R11: Byte accesses never fault, whatever the address alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; registers and array writes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the output registers |
| req_cs | input | 1 | Select: 1 performs the request, 0 does nothing |
| req_we | input | 1 | 1 store, 0 load |
| req_word | input | 1 | 1 word access, 0 byte access |
| req_base | input | 32 | Base value from the register file |
| req_offset | input | OFFSET_W | Signed immediate offset |
| req_wdata | input | 32 | Store data; bits 7:0 only for byte stores |
| ld_data | output | 32 | Registered, extended load result |
| ld_valid | output | 1 | High for one cycle after a completed load |
| bus_fault | output | 1 | High for one cycle after a misaligned word access |

## Verification
A wrong byte lane or endian order in the array does not show up when the store happens. It shows up only when a later load reads those locations, on the clock after that load request. The bench therefore reads every stored word back both as a word and as single bytes. A corrupted write from a refused or deselected store is just as latent: it appears only when the bench reloads the location it could have hit. Faults and load data are registered, so a broken alignment check or extension shows at the ports exactly one cycle after the offending request.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
   localparam int DATA_W     = 32;
   localparam int BYTE_W     = 8;
   localparam int WORD_BYTES = DATA_W / BYTE_W;
   localparam int LANE_SEL_W = $clog2(WORD_BYTES);

   typedef enum logic {
      SZ_BYTE = 1'b0,
      SZ_WORD = 1'b1
   } acc_size_e;
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
   import lsu_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int OFFSET_W = 16
) (
   input  logic [DATA_W-1:0]   base,
   input  logic [OFFSET_W-1:0] offset,
   input  acc_size_e           size,
   output logic [ADDR_W-1:0]   eff_addr,
   output logic                misaligned
);
   logic [DATA_W-1:0] offset_ext;
   logic [DATA_W-1:0] sum;

   generate
      if (OFFSET_W < DATA_W) begin : g_sext
         assign offset_ext = {{(DATA_W-OFFSET_W){offset[OFFSET_W-1]}}, offset};
      end else begin : g_full
         assign offset_ext = offset[DATA_W-1:0];
      end
   endgenerate

   assign sum        = base + offset_ext;
   assign eff_addr   = sum[ADDR_W-1:0];
   assign misaligned = (size == SZ_WORD) && (sum[LANE_SEL_W-1:0] != '0);
endmodule

// File: rtl/lsu_bytemem.sv
module lsu_bytemem
   import lsu_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              wr_en,
   input  acc_size_e         size,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd_word,
   output logic [BYTE_W-1:0] rd_byte
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [BYTE_W-1:0] mem      [DEPTH];
   logic [ADDR_W-1:0] lane_addr[WORD_BYTES];
   logic [BYTE_W-1:0] lane_wd  [WORD_BYTES];
   logic [BYTE_W-1:0] lane_rd  [WORD_BYTES];
   logic              lane_en  [WORD_BYTES];

   generate
      for (genvar k = 0; k < WORD_BYTES; k++) begin : g_lane
         // lane 0 is the lowest address and carries the most significant byte
         assign lane_addr[k] = addr + ADDR_W'(k);
         if (k == 0) begin : g_first
            assign lane_wd[k] = (size == SZ_WORD) ? wdata[DATA_W-1 -: BYTE_W]
                                                  : wdata[BYTE_W-1:0];
            assign lane_en[k] = wr_en;
         end else begin : g_rest
            assign lane_wd[k] = wdata[DATA_W-1-BYTE_W*k -: BYTE_W];
            assign lane_en[k] = wr_en && (size == SZ_WORD);
         end
         assign lane_rd[k] = mem[lane_addr[k]];
      end
   endgenerate

   always_comb begin
      for (int k = 0; k < WORD_BYTES; k++) begin
         rd_word[DATA_W-1-BYTE_W*k -: BYTE_W] = lane_rd[k];
      end
   end

   assign rd_byte = lane_rd[0];

   always_ff @(posedge clk) begin
      for (int k = 0; k < WORD_BYTES; k++) begin
         if (lane_en[k]) mem[lane_addr[k]] <= lane_wd[k];
      end
   end
endmodule

// File: rtl/lsu_extend.sv
module lsu_extend
   import lsu_pkg::*;
(
   input  acc_size_e         size,
   input  logic [DATA_W-1:0] word_in,
   input  logic [BYTE_W-1:0] byte_in,
   output logic [DATA_W-1:0] result
);
   always_comb begin
      if (size == SZ_WORD) result = word_in;
      else                 result = {{(DATA_W-BYTE_W){byte_in[BYTE_W-1]}}, byte_in};
   end
endmodule

// File: rtl/bytemem_lsu.sv
module bytemem_lsu
   import lsu_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int OFFSET_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_cs,
   input  logic                req_we,
   input  logic                req_word,
   input  logic [31:0]         req_base,
   input  logic [OFFSET_W-1:0] req_offset,
   input  logic [31:0]         req_wdata,
   output logic [31:0]         ld_data,
   output logic                ld_valid,
   output logic                bus_fault
);
   generate
      if (ADDR_W < LANE_SEL_W || ADDR_W > 16) begin : g_bad_addr
         $error("bytemem_lsu: ADDR_W must lie in 2..16");
      end
      if (OFFSET_W < 1 || OFFSET_W > DATA_W) begin : g_bad_off
         $error("bytemem_lsu: OFFSET_W must lie in 1..32");
      end
   endgenerate

   acc_size_e         size;
   logic [ADDR_W-1:0] eff_addr;
   logic              misaligned;
   logic              do_write, do_read, do_fault;
   logic [DATA_W-1:0] rd_word, ld_next;
   logic [BYTE_W-1:0] rd_byte;

   assign size = req_word ? SZ_WORD : SZ_BYTE;

   lsu_agen #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W)) i_agen (
      .base(req_base), .offset(req_offset), .size(size),
      .eff_addr(eff_addr), .misaligned(misaligned)
   );

   assign do_write = req_cs &&  req_we && !misaligned;
   assign do_read  = req_cs && !req_we && !misaligned;
   assign do_fault = req_cs &&  misaligned;

   lsu_bytemem #(.ADDR_W(ADDR_W)) i_mem (
      .clk(clk), .wr_en(do_write), .size(size), .addr(eff_addr),
      .wdata(req_wdata), .rd_word(rd_word), .rd_byte(rd_byte)
   );

   lsu_extend i_ext (
      .size(size), .word_in(rd_word), .byte_in(rd_byte), .result(ld_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ld_data   <= '0;
         ld_valid  <= 1'b0;
         bus_fault <= 1'b0;
      end else begin
         ld_valid  <= do_read;
         bus_fault <= do_fault;
         if (do_read) ld_data <= ld_next;
      end
   end

   a_r6_fault_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_cs && req_word && (eff_addr[1:0] != 2'b00) |=> bus_fault);
   a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ld_valid, bus_fault}));
   a_r8_fault_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
      bus_fault |-> $stable(ld_data) && !ld_valid);
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_cs |=> !ld_valid && !bus_fault && $stable(ld_data));
   a_r3_byte_sext: assert property (@(posedge clk) disable iff (!rst_n)
      req_cs && !req_we && !req_word |=> ld_data[31:8] == {24{ld_data[7]}});
   a_r11_byte_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
      req_cs && !req_word |=> !bus_fault);
endmodule

// File: tb/test_bytemem_lsu.sv
module test_bytemem_lsu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_cs = 1'b0, req_we = 1'b0, req_word = 1'b0;
   logic [31:0] req_base = '0, req_wdata = '0;
   logic [15:0] req_offset = '0;
   logic [31:0] ld_data;
   logic        ld_valid, bus_fault;

   always #2.5 clk = ~clk;

   bytemem_lsu i_bytemem_lsu (
      .clk(clk), .rst_n(rst_n), .req_cs(req_cs), .req_we(req_we),
      .req_word(req_word), .req_base(req_base), .req_offset(req_offset),
      .req_wdata(req_wdata), .ld_data(ld_data), .ld_valid(ld_valid),
      .bus_fault(bus_fault)
   );

   typedef struct {
      int          due;
      logic        v;
      logic        f;
      logic [31:0] d;
      string       tag;
   } exp_t;

   exp_t        q[$];
   int          cyc = 0;
   int          checks = 0, errors = 0;
   logic [7:0]  model[256];
   logic [31:0] exp_rd = '0;

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: compare due items away from the active edge
   always @(negedge clk) begin
      if (q.size() > 0 && q[0].due == cyc) begin
         exp_t e;
         e = q.pop_front();
         checks++;
         if (ld_valid !== e.v || bus_fault !== e.f || ld_data !== e.d) begin
            errors++;
            $display("FAIL %s: got valid=%0b fault=%0b data=%h, expected valid=%0b fault=%0b data=%h",
                     e.tag, ld_valid, bus_fault, ld_data, e.v, e.f, e.d);
         end
      end
   end

   task automatic issue(input logic cs, input logic we, input logic word,
                        input logic [31:0] base, input logic [15:0] off,
                        input logic [31:0] wd, input string tag);
      logic [31:0] ea32;
      logic [7:0]  a0, a1, a2, a3;
      logic        mis;
      exp_t        e;
      @(negedge clk);
      req_cs = cs; req_we = we; req_word = word;
      req_base = base; req_offset = off; req_wdata = wd;
      ea32 = base + {{16{off[15]}}, off};
      a0 = ea32[7:0]; a1 = a0 + 8'd1; a2 = a0 + 8'd2; a3 = a0 + 8'd3;
      mis = word && (ea32[1:0] != 2'b00);
      e.due = cyc + 1;
      e.v = 1'b0;
      e.f = cs && mis;
      if (cs && !mis) begin
         if (we) begin
            if (word) begin
               model[a0] = wd[31:24]; model[a1] = wd[23:16];
               model[a2] = wd[15:8];  model[a3] = wd[7:0];
            end else begin
               model[a0] = wd[7:0];
            end
         end else begin
            e.v = 1'b1;
            exp_rd = word ? {model[a0], model[a1], model[a2], model[a3]}
                          : {{24{model[a0][7]}}, model[a0]};
         end
      end
      e.d = exp_rd;
      e.tag = tag;
      q.push_back(e);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++; // R10 reset state
      if (ld_data !== 32'h0 || ld_valid !== 1'b0 || bus_fault !== 1'b0) begin
         errors++;
         $display("FAIL R10: got data=%h valid=%0b fault=%0b, expected 0 0 0",
                  ld_data, ld_valid, bus_fault);
      end
      rst_n = 1'b1;

      // R5 and R2: word store, read back as word and as bytes
      issue(1, 1, 1, 32'h10, 16'h0, 32'h11223344, "R5 word store");
      issue(1, 0, 1, 32'h10, 16'h0, 32'h0, "R5 word load");
      issue(1, 0, 0, 32'h10, 16'h0, 32'h0, "R2 byte at A is msb");
      issue(1, 0, 0, 32'h10, 16'h3, 32'h0, "R2 R11 byte at A+3 is lsb");
      // R4 and R1: byte store with negative offset into a word
      issue(1, 1, 1, 32'h1C, 16'h0, 32'hCAFEBABE, "R5 word store 2");
      issue(1, 1, 0, 32'h1F, 16'hFFFF, 32'h12345680, "R4 R1 byte store");
      issue(1, 0, 1, 32'h1C, 16'h0, 32'h0, "R4 neighbours unchanged");
      issue(1, 0, 0, 32'h1E, 16'h0, 32'h0, "R3 sign extend 0x80");
      issue(1, 0, 0, 32'h1D, 16'h0, 32'h0, "R3 sign extend 0xFE");
      issue(1, 0, 0, 32'h11, 16'h0, 32'h0, "R3 positive byte");
      // R1: wrap of address and negative offset
      issue(1, 1, 1, 32'h200, 16'h4, 32'hDEADBEEF, "R1 wrapped store");
      issue(1, 0, 1, 32'h105, 16'hFFFF, 32'h0, "R1 negative offset load");
      // R6 R8: misaligned word load keeps data
      issue(1, 0, 1, 32'h10, 16'h1, 32'h0, "R6 R8 misaligned load");
      // R7: misaligned word store leaves memory alone
      issue(1, 1, 1, 32'h10, 16'h2, 32'hFFFFFFFF, "R6 R7 misaligned store");
      issue(1, 0, 1, 32'h10, 16'h0, 32'h0, "R7 memory intact");
      issue(1, 0, 0, 32'h12, 16'h0, 32'h0, "R7 byte intact");
      // R9: deselected write does nothing
      issue(0, 1, 1, 32'h10, 16'h0, 32'h0, "R9 deselected write");
      issue(0, 0, 0, 32'h10, 16'h0, 32'h0, "R9 deselected read");
      issue(1, 0, 1, 32'h10, 16'h0, 32'h0, "R9 memory after deselect");
      // R11: byte store at odd address
      issue(1, 1, 0, 32'h13, 16'h0, 32'h000000A5, "R11 odd byte store");
      issue(1, 0, 1, 32'h10, 16'h0, 32'h0, "R11 R4 word after byte store");
      issue(0, 0, 0, 32'h0, 16'h0, 32'h0, "R9 idle");

      repeat (4) @(negedge clk);
      if (q.size() != 0) begin
         errors++;
         $display("FAIL scoreboard: got %0d pending, expected 0", q.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule